// File: doc/BRIEF.md
# Serial Line-Count Format Decoder

This block sits behind a sync separator that reports the number of scan lines per frame as a serial bit stream. It rebuilds that count and turns it into a video format code. A vertical sync strobe empties and re-arms a capture register. After the strobe ends, each horizontal sync leading edge shifts in one data bit, and a field's count is complete when the last of its bits has arrived. The sender always doubles the line count, on the assumption of two fields per frame. For this reason the decoder halves the value for progressive formats and reports the true lines per frame.

The completed count is matched against a window of ±TOL lines around each standard doubled total. A result reaches the outputs only when two completed fields in a row give the same format code. Each update of the outputs comes with a one-cycle valid pulse. All inputs are synchronous to the system clock. Both sync strobes are active-high levels, and the block finds their edges itself.

Top module: `line_fmt_decoder`

## Requirements
- R1: While rst_ni is low and after it is released, lines_o is 0, fmt_o is 0 (unknown), prog_o is 0 and valid_o is 0, until the first confirmed field.
- R2: After vsync_i falls, the next CNT_W (default 11) rising edges of hsync_i each sample sdata_i in the clock cycle where the edge is first seen. The bits are taken most significant first, and the CNT_W-th bit completes the field.
- R3: A rising edge of hsync_i is ignored in three cases: while vsync_i is high, before the first falling edge of vsync_i after reset, and after the CNT_W-th bit of the field.
- R4: A rising edge of vsync_i that arrives before a field is complete discards the partial count. That field gives no result, and the next completed field is treated as the first of a new pair.
- R5: fmt_o uses the codes 1=480i (525), 2=480p (1050), 3=576i (625), 4=576p (1250), 5=720p (1500), 6=1080i (1125) and 7=1080p (2250). The value in brackets is the doubled count, and a code matches when the received count is within ±TOL (default 3) of it. The 2250 window is reachable only when CNT_W is 12 or more.
- R6: A count that lies outside every window is classified as code 0 (unknown).
- R7: For codes 2, 4, 5 and 7, prog_o is 1 and lines_o is the received count shifted right by one. For all other codes, prog_o is 0 and lines_o is the received count.
- R8: The outputs update, and valid_o pulses, only when a completed field has the same code as the completed field just before it, with no discarded field between them. Otherwise the outputs hold their values.
- R9: valid_o is high for exactly one cycle. It rises at the second clock edge after the edge that samples the completing hsync_i rise, and the new outputs appear at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial line-count data bit |
| hsync_i | input | 1 | Horizontal sync strobe, active high; its rising edge shifts a bit |
| vsync_i | input | 1 | Vertical sync strobe, active high; clears and re-arms capture |
| lines_o | output | CNT_W | Corrected lines per frame of the confirmed format |
| fmt_o | output | 3 | Confirmed format code (0 = unknown) |
| prog_o | output | 1 | 1 for a progressive format |
| valid_o | output | 1 | One-cycle pulse on each output update |

## Verification
The assertions assume that sdata_i, hsync_i and vsync_i are already synchronous to clk_i. They also assume that a sync edge never lands in the same cycle as an edge of the other strobe, and that two vertical strobes are far enough apart that no two fields complete in adjacent cycles. The stimulus changes inputs only on falling clock edges. It holds each horizontal strobe high for two cycles and low for at least three, and it leaves idle cycles between the end of a vertical strobe and the first horizontal edge. Under these spacing rules, every rise is seen exactly once and the window checks stay free of overlap.

// File: rtl/linefmt_pkg.sv
package linefmt_pkg;
  localparam int NUM_FMT = 7;
  localparam int NOM_W   = 12;

  typedef enum logic [2:0] {
    FMT_UNKNOWN = 3'd0,
    FMT_480I    = 3'd1,
    FMT_480P    = 3'd2,
    FMT_576I    = 3'd3,
    FMT_576P    = 3'd4,
    FMT_720P    = 3'd5,
    FMT_1080I   = 3'd6,
    FMT_1080P   = 3'd7
  } fmt_e;

  // doubled line total the sender reports for each format
  function automatic logic [NOM_W-1:0] fmt_nominal(input fmt_e f);
    case (f)
      FMT_480I:  return NOM_W'(525);
      FMT_480P:  return NOM_W'(1050);
      FMT_576I:  return NOM_W'(625);
      FMT_576P:  return NOM_W'(1250);
      FMT_720P:  return NOM_W'(1500);
      FMT_1080I: return NOM_W'(1125);
      FMT_1080P: return NOM_W'(2250);
      default:   return '0;
    endcase
  endfunction

  function automatic logic fmt_is_prog(input fmt_e f);
    return (f == FMT_480P) || (f == FMT_576P) || (f == FMT_720P) || (f == FMT_1080P);
  endfunction
endpackage

// File: rtl/lf_edge_det.sv
module lf_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  if (FALLING) begin : g_fall
    assign edge_o = sig_q & ~sig_i;
  end else begin : g_rise
    assign edge_o = sig_i & ~sig_q;
  end
endmodule

// File: rtl/lf_shift_capture.sv
module lf_shift_capture #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             h_rise_i,
  input  logic             v_level_i,
  input  logic             v_rise_i,
  input  logic             v_fall_i,
  output logic             done_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] word_o
);
  localparam int BC_W = $clog2(CNT_W + 1);
  localparam logic [BC_W-1:0] LAST = BC_W'(CNT_W - 1);
  localparam logic [BC_W-1:0] FULL = BC_W'(CNT_W);

  logic [CNT_W-1:0] sr_q;
  logic [BC_W-1:0]  cnt_q;
  logic             armed_q;
  logic [CNT_W-1:0] sr_next;

  assign sr_next = {sr_q[CNT_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      word_o  <= '0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (v_level_i) begin
        // partial field dropped on a new vertical strobe
        if (v_rise_i && armed_q && (cnt_q != FULL)) abort_o <= 1'b1;
        sr_q    <= '0;
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (v_fall_i) begin
        armed_q <= 1'b1;
      end else if (armed_q && h_rise_i && (cnt_q != FULL)) begin
        sr_q  <= sr_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          done_o <= 1'b1;
          word_o <= sr_next;
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_clear_on_vsync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_level_i |=> (cnt_q == '0) && !done_o);
  p_done_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == FULL));
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_no_done_unarmed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !done_o);
endmodule

// File: rtl/lf_classify.sv
module lf_classify
  import linefmt_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 3
) (
  input  logic [CNT_W-1:0] word_i,
  output fmt_e             fmt_o,
  output logic             prog_o,
  output logic [CNT_W-1:0] lines_o
);
  localparam int CMP_W = ((CNT_W > NOM_W) ? CNT_W : NOM_W) + 2;

  logic [CMP_W-1:0]   raw_w;
  logic [NUM_FMT-1:0] hit;

  assign raw_w = CMP_W'(word_i);

  for (genvar k = 0; k < NUM_FMT; k++) begin : g_win
    localparam fmt_e CODE = fmt_e'(3'(k + 1));
    localparam logic [CMP_W-1:0] LO = CMP_W'(fmt_nominal(CODE)) - CMP_W'(TOL);
    localparam logic [CMP_W-1:0] HI = CMP_W'(fmt_nominal(CODE)) + CMP_W'(TOL);
    assign hit[k] = (raw_w >= LO) && (raw_w <= HI);
  end

  always_comb begin
    fmt_o = FMT_UNKNOWN;
    for (int k = 0; k < NUM_FMT; k++) begin
      if (hit[k]) fmt_o = fmt_e'(3'(k + 1));
    end
    prog_o  = fmt_is_prog(fmt_o);
    lines_o = prog_o ? (word_i >> 1) : word_i;
  end

  always_comb begin
    p_win_exclusive_r5: assert ($onehot0(hit));
  end
endmodule

// File: rtl/lf_confirm.sv
module lf_confirm
  import linefmt_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             abort_i,
  input  fmt_e             fmt_i,
  input  logic             prog_i,
  input  logic [CNT_W-1:0] lines_i,
  output fmt_e             fmt_o,
  output logic             prog_o,
  output logic [CNT_W-1:0] lines_o,
  output logic             valid_o
);
  fmt_e prev_q;
  logic prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= FMT_UNKNOWN;
      prev_vld_q <= 1'b0;
      fmt_o      <= FMT_UNKNOWN;
      prog_o     <= 1'b0;
      lines_o    <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (abort_i) begin
        prev_vld_q <= 1'b0;
      end else if (done_i) begin
        prev_q     <= fmt_i;
        prev_vld_q <= 1'b1;
        if (prev_vld_q && (prev_q == fmt_i)) begin
          fmt_o   <= fmt_i;
          prog_o  <= prog_i;
          lines_o <= lines_i;
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(done_i));
  p_fmt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fmt_o) |-> valid_o);
  p_lines_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lines_o) |-> valid_o);
  p_prog_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> fmt_is_prog(fmt_o));
endmodule

// File: rtl/line_fmt_decoder.sv
module line_fmt_decoder
  import linefmt_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [CNT_W-1:0] lines_o,
  output logic [2:0]       fmt_o,
  output logic             prog_o,
  output logic             valid_o
);
  logic             h_rise, v_rise, v_fall;
  logic             done, abort;
  logic [CNT_W-1:0] word;
  fmt_e             cls_fmt, out_fmt;
  logic             cls_prog;
  logic [CNT_W-1:0] cls_lines;

  lf_edge_det #(.FALLING(1'b0)) u_h_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(hsync_i), .edge_o(h_rise));
  lf_edge_det #(.FALLING(1'b0)) u_v_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(vsync_i), .edge_o(v_rise));
  lf_edge_det #(.FALLING(1'b1)) u_v_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(vsync_i), .edge_o(v_fall));

  lf_shift_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .h_rise_i (h_rise),
    .v_level_i(vsync_i),
    .v_rise_i (v_rise),
    .v_fall_i (v_fall),
    .done_o   (done),
    .abort_o  (abort),
    .word_o   (word)
  );

  lf_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .word_i (word),
    .fmt_o  (cls_fmt),
    .prog_o (cls_prog),
    .lines_o(cls_lines)
  );

  lf_confirm #(.CNT_W(CNT_W)) u_conf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .abort_i(abort),
    .fmt_i  (cls_fmt),
    .prog_i (cls_prog),
    .lines_i(cls_lines),
    .fmt_o  (out_fmt),
    .prog_o (prog_o),
    .lines_o(lines_o),
    .valid_o(valid_o)
  );

  assign fmt_o = out_fmt;

  p_no_valid_in_vsync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vsync_i) && vsync_i |-> !valid_o);
endmodule

// File: tb/line_fmt_decoder_tb.sv
module line_fmt_decoder_tb;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sdata_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
  logic [CNT_W-1:0] lines_o;
  logic [2:0] fmt_o;
  logic prog_o, valid_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_fmt_decoder #(.CNT_W(CNT_W), .TOL(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata_i), .hsync_i(hsync_i),
    .vsync_i(vsync_i), .lines_o(lines_o), .fmt_o(fmt_o), .prog_o(prog_o),
    .valid_o(valid_o));

  // {count[26:16], confirm[15], fmt[14:12], lines[11:1], prog[0]}
  localparam logic [26:0] VEC [0:16] = '{
    {11'd525,  1'b0, 3'd0, 11'd0,    1'b0},
    {11'd525,  1'b1, 3'd1, 11'd525,  1'b0},
    {11'd527,  1'b1, 3'd1, 11'd527,  1'b0},
    {11'd1050, 1'b0, 3'd1, 11'd527,  1'b0},
    {11'd1047, 1'b1, 3'd2, 11'd523,  1'b1},
    {11'd1046, 1'b0, 3'd2, 11'd523,  1'b1},
    {11'd1054, 1'b1, 3'd0, 11'd1054, 1'b0},
    {11'd625,  1'b0, 3'd0, 11'd1054, 1'b0},
    {11'd628,  1'b1, 3'd3, 11'd628,  1'b0},
    {11'd1250, 1'b0, 3'd3, 11'd628,  1'b0},
    {11'd1252, 1'b1, 3'd4, 11'd626,  1'b1},
    {11'd1500, 1'b0, 3'd4, 11'd626,  1'b1},
    {11'd1497, 1'b1, 3'd5, 11'd748,  1'b1},
    {11'd1125, 1'b0, 3'd5, 11'd748,  1'b1},
    {11'd1122, 1'b1, 3'd6, 11'd1122, 1'b0},
    {11'd2045, 1'b0, 3'd6, 11'd1122, 1'b0},
    {11'd2047, 1'b1, 3'd0, 11'd2047, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_bit(input logic b, output logic [2:0] vp);
    @(negedge clk); sdata_i = b; hsync_i = 1'b1;
    @(negedge clk); vp[2] = valid_o;
    @(negedge clk); vp[1] = valid_o; hsync_i = 1'b0;
    @(negedge clk); vp[0] = valid_o;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [CNT_W-1:0] val, input int nbits,
                           output logic [2:0] vp);
    for (int i = 0; i < nbits; i++) pulse_bit(val[CNT_W-1-i], vp);
  endtask

  task automatic send_field(input logic [CNT_W-1:0] val, input int nbits,
                            input int extra, output logic [2:0] vp);
    logic [2:0] dummy;
    @(negedge clk); vsync_i = 1'b1;
    repeat (3) @(negedge clk);
    vsync_i = 1'b0;
    repeat (2) @(negedge clk);
    send_bits(val, nbits, vp);
    for (int e = 0; e < extra; e++) pulse_bit(1'b1, dummy);
  endtask

  task automatic chk_out(input string tag, input int f, input int l, input int p);
    chk({tag, " fmt"}, int'(fmt_o), f);
    chk({tag, " lines"}, int'(lines_o), l);
    chk({tag, " prog"}, int'(prog_o), p);
  endtask

  always @(negedge clk) begin
    if (!finished && $time > 3000000) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] vp;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid_o), 0);
    chk_out("R1 reset", 0, 0, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_out("R1 after release", 0, 0, 0);

    // table walk: R2 R5 R6 R7 R8 R9
    for (int i = 0; i < 17; i++) begin
      send_field(VEC[i][26:16], CNT_W, 0, vp);
      chk($sformatf("R9/R8 vec%0d pulse", i), int'(vp), VEC[i][15] ? 3'b010 : 3'b000);
      chk_out($sformatf("R5/R6/R7 vec%0d", i), int'(VEC[i][14:12]),
              int'(VEC[i][11:1]), int'(VEC[i][0]));
    end

    // R4: partial field breaks the pair
    send_field(11'd525, CNT_W, 0, vp);
    chk("R8 differ", int'(vp), 0);
    send_field(11'd525, 5, 0, vp);
    send_field(11'd525, CNT_W, 0, vp);
    chk("R4 after abort", int'(vp), 0);
    chk_out("R4 hold", 0, 2047, 0);
    send_field(11'd525, CNT_W, 0, vp);
    chk("R4 repaired", int'(vp), 3'b010);
    chk_out("R4 repaired", 1, 525, 0);

    // R3: edges beyond the last bit ignored
    send_field(11'd625, CNT_W, 4, vp);
    chk("R3 extra first", int'(vp), 0);
    send_field(11'd625, CNT_W, 0, vp);
    chk("R3 extra confirm", int'(vp), 3'b010);
    chk_out("R3 extra", 3, 625, 0);

    // R1 mid-run reset, then R3 edges before first vsync
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk_out("R1 mid reset", 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    send_bits(11'd625, CNT_W, vp);
    chk("R3 pre-vsync", int'(vp), 0);
    send_field(11'd625, CNT_W, 0, vp);
    chk("R3 first field", int'(vp), 0);
    chk_out("R3 first field", 0, 0, 0);
    send_field(11'd625, CNT_W, 0, vp);
    chk("R2 confirm", int'(vp), 3'b010);
    chk_out("R2 confirm", 3, 625, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule